// File: doc/BRIEF.md
# Enabled Line Decoder with Active-Low Outputs

This block turns a binary address into a single active-low line. In its default form it takes a 3-bit address and drives eight outputs. When every enable is at its active level, the line named by the address is pulled low and the other seven lines stay high. There are three enables. One is true when high. The other two are true when low. If any of them is inactive, all outputs stay high.

The mixed enable polarities let the block do two more jobs. First, it can act as a 1-to-8 demultiplexer. A serial data bit is placed on one active-low enable, and the select lines steer it to one output. The chosen line then follows the data, and the other lines stay high. Second, a build parameter can join two units into a 16-line decoder. The extra address bit turns off the lower bank through an active-low enable and turns on the upper bank through the active-high enable. The external enables are merged once and shared by both banks. The block is purely combinational.

Top module: `bank_decoder`

## Requirements
- R1: In the 8-line build, with en_hi=1, en_lo_a_n=0 and en_lo_b_n=0, output bit out_n[addr] is 0 and every other output bit is 1.
- R2: When en_hi is 0, every output bit is 1, whatever the address.
- R3: When en_lo_a_n is 1, every output bit is 1, whatever the address.
- R4: When en_lo_b_n is 1, every output bit is 1, whatever the address.
- R5: For demultiplexer use, data is applied to en_lo_a_n while en_hi=1 and en_lo_b_n=0. Output bit out_n[addr] equals the data bit, and every other output bit is 1.
- R6: In the 16-line build (VARIANT=DEC_PAIR, 4-bit address), with all enables active, out_n[addr] is 0 and the other 15 bits are 1. Addresses with bit 3 = 0 map to lines 0 to 7, and addresses with bit 3 = 1 map to lines 8 to 15.
- R7: In the 16-line build, an inactive external enable forces all 16 output bits to 1.
- R8: At no time is more than one output bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | SEL_W, plus 1 in the paired build | Binary line address; in the paired build the top bit picks the bank |
| en_hi | input | 1 | Enable, true when high |
| en_lo_a_n | input | 1 | Enable, true when low; used as the data input for demultiplexing |
| en_lo_b_n | input | 1 | Enable, true when low |
| out_n | output | 2**width(addr) | Decoded lines, active low |

## Verification
The bench builds two copies of the block, both with SEL_W=3. The first copy uses the single variant. It is used for an exhaustive address sweep, for each enable being turned off on its own, and for demultiplexing with both data values at every select code. The second copy uses the paired variant. Its 16-line build shows the bank handover at address 8. It also shows that the merged external enables turn off both banks together.

// File: rtl/dec_pkg.sv
package dec_pkg;

   typedef enum logic {
      DEC_SINGLE = 1'b0,
      DEC_PAIR   = 1'b1
   } dec_variant_e;

   localparam int unsigned DEC_SEL_W_MAX = 6;

   function automatic int unsigned dec_lines(input int unsigned sel_w);
      return 32'd1 << sel_w;
   endfunction

endpackage

// File: rtl/dec_enable_gate.sv
module dec_enable_gate #(
   parameter int unsigned N_HI = 1,
   parameter int unsigned N_LO = 2
) (
   input  logic [N_HI-1:0] en_hi,
   input  logic [N_LO-1:0] en_lo_n,
   output logic            active
);

   initial begin
      if (N_HI < 1 || N_LO < 1)
         $error("dec_enable_gate: each enable group needs at least one input");
   end

   always_comb begin
      active = (&en_hi) & ~(|en_lo_n);
   end

endmodule

// File: rtl/dec_onehot_core.sv
module dec_onehot_core #(
   parameter int unsigned SEL_W = 3,
   localparam int unsigned LINES = dec_pkg::dec_lines(SEL_W)
) (
   input  logic [SEL_W-1:0] sel,
   input  logic             ena,
   output logic [LINES-1:0] line
);

   initial begin
      if (SEL_W < 1 || SEL_W > dec_pkg::DEC_SEL_W_MAX)
         $error("dec_onehot_core: SEL_W out of range");
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign line[i] = ena && (sel == SEL_W'(i));
   end

endmodule

// File: rtl/dec_unit.sv
module dec_unit #(
   parameter int unsigned SEL_W = 3,
   localparam int unsigned LINES = dec_pkg::dec_lines(SEL_W)
) (
   input  logic [SEL_W-1:0] addr,
   input  logic             en_hi,
   input  logic             en_lo_a_n,
   input  logic             en_lo_b_n,
   output logic [LINES-1:0] out_n
);

   logic             gate_on;
   logic [LINES-1:0] hot;

   dec_enable_gate #(.N_HI(1), .N_LO(2)) gate_i (
      .en_hi   (en_hi),
      .en_lo_n ({en_lo_b_n, en_lo_a_n}),
      .active  (gate_on)
   );

   dec_onehot_core #(.SEL_W(SEL_W)) core_i (
      .sel  (addr),
      .ena  (gate_on),
      .line (hot)
   );

   assign out_n = ~hot;

   // Checks on the unit outputs against its enables and address
   always_comb begin
      if (!$isunknown({addr, en_hi, en_lo_a_n, en_lo_b_n})) begin
         // R8: never more than one low line
         p_at_most_one_low_r8: assert ($countones(~out_n) <= 1);
         // R1: enabled unit drives the addressed line low
         if (en_hi && !en_lo_a_n && !en_lo_b_n)
            p_sel_line_low_r1: assert (out_n[addr] == 1'b0);
         // R2: inactive high enable blanks the unit
         if (!en_hi)
            p_hi_off_blank_r2: assert (&out_n);
         // R3: inactive first low enable blanks the unit
         if (en_lo_a_n)
            p_lo_a_off_blank_r3: assert (&out_n);
         // R4: inactive second low enable blanks the unit
         if (en_lo_b_n)
            p_lo_b_off_blank_r4: assert (&out_n);
      end
   end

endmodule

// File: rtl/bank_decoder.sv
module bank_decoder #(
   parameter int unsigned SEL_W = 3,
   parameter dec_pkg::dec_variant_e VARIANT = dec_pkg::DEC_SINGLE,
   localparam int unsigned ADDR_W = SEL_W + ((VARIANT == dec_pkg::DEC_PAIR) ? 1 : 0),
   localparam int unsigned OUT_N  = dec_pkg::dec_lines(ADDR_W)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              en_hi,
   input  logic              en_lo_a_n,
   input  logic              en_lo_b_n,
   output logic [OUT_N-1:0]  out_n
);

   localparam int unsigned UNIT_N = dec_pkg::dec_lines(SEL_W);

   initial begin
      if (SEL_W < 1 || SEL_W > dec_pkg::DEC_SEL_W_MAX)
         $error("bank_decoder: SEL_W must lie in 1..%0d", dec_pkg::DEC_SEL_W_MAX);
   end

   if (VARIANT == dec_pkg::DEC_SINGLE) begin : g_single
      dec_unit #(.SEL_W(SEL_W)) unit_i (
         .addr      (addr),
         .en_hi     (en_hi),
         .en_lo_a_n (en_lo_a_n),
         .en_lo_b_n (en_lo_b_n),
         .out_n     (out_n)
      );
   end else begin : g_pair
      logic grp_on;
      logic grp_n;
      logic bank_sel;

      // External enables merged once, shared by both banks
      dec_enable_gate #(.N_HI(1), .N_LO(2)) grp_gate_i (
         .en_hi   (en_hi),
         .en_lo_n ({en_lo_b_n, en_lo_a_n}),
         .active  (grp_on)
      );
      assign grp_n    = ~grp_on;
      assign bank_sel = addr[ADDR_W-1];

      // Lower bank: top address bit on an active-low enable
      dec_unit #(.SEL_W(SEL_W)) lo_bank_i (
         .addr      (addr[SEL_W-1:0]),
         .en_hi     (1'b1),
         .en_lo_a_n (grp_n),
         .en_lo_b_n (bank_sel),
         .out_n     (out_n[UNIT_N-1:0])
      );

      // Upper bank: top address bit on the active-high enable
      dec_unit #(.SEL_W(SEL_W)) hi_bank_i (
         .addr      (addr[SEL_W-1:0]),
         .en_hi     (bank_sel),
         .en_lo_a_n (grp_n),
         .en_lo_b_n (1'b0),
         .out_n     (out_n[OUT_N-1:UNIT_N])
      );

      always_comb begin
         if (!$isunknown({addr, en_hi, en_lo_a_n, en_lo_b_n})) begin
            // R6: exactly one of the joined lines is low when enabled
            if (en_hi && !en_lo_a_n && !en_lo_b_n)
               p_one_low_pair_r6: assert ($countones(~out_n) == 1);
            // R7: any inactive external enable blanks both banks
            if (!en_hi || en_lo_a_n || en_lo_b_n)
               p_pair_blank_r7: assert (&out_n);
         end
      end
   end

endmodule

// File: tb/bank_decoder_tb_top.sv
module bank_decoder_tb_top;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [2:0]  a8;
   logic        hi8, la8, lb8;
   logic [7:0]  o8;
   logic [3:0]  a16;
   logic        hi16, la16, lb16;
   logic [15:0] o16;

   bank_decoder #(.SEL_W(3), .VARIANT(dec_pkg::DEC_SINGLE)) dut_i (
      .addr (a8), .en_hi (hi8), .en_lo_a_n (la8), .en_lo_b_n (lb8), .out_n (o8)
   );

   bank_decoder #(.SEL_W(3), .VARIANT(dec_pkg::DEC_PAIR)) casc_i (
      .addr (a16), .en_hi (hi16), .en_lo_a_n (la16), .en_lo_b_n (lb16), .out_n (o16)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive8(input logic [2:0] a, input logic h, input logic la, input logic lb);
      @(posedge clk);
      #1;
      a8 = a; hi8 = h; la8 = la; lb8 = lb;
      @(negedge clk);
   endtask

   task automatic drive16(input logic [3:0] a, input logic h, input logic la, input logic lb);
      @(posedge clk);
      #1;
      a16 = a; hi16 = h; la16 = la; lb16 = lb;
      @(negedge clk);
   endtask

   task automatic t_idle;
      drive8(3'd0, 1'b0, 1'b1, 1'b1);
      check("R2 idle 8-line", {8'h00, o8}, 16'h00FF);
      drive16(4'd0, 1'b0, 1'b1, 1'b1);
      check("R7 idle 16-line", o16, 16'hFFFF);
   endtask

   task automatic t_decode8;
      for (int a = 0; a < 8; a++) begin
         drive8(3'(a), 1'b1, 1'b0, 1'b0);
         check("R1 decode", {8'h00, o8}, {8'h00, ~(8'd1 << a)});
         check("R8 single low", 16'($countones(~o8)), 16'd1);
      end
   endtask

   task automatic t_disable8;
      for (int a = 0; a < 8; a++) begin
         drive8(3'(a), 1'b0, 1'b0, 1'b0);
         check("R2 en_hi off", {8'h00, o8}, 16'h00FF);
         drive8(3'(a), 1'b1, 1'b1, 1'b0);
         check("R3 en_lo_a_n off", {8'h00, o8}, 16'h00FF);
         drive8(3'(a), 1'b1, 1'b0, 1'b1);
         check("R4 en_lo_b_n off", {8'h00, o8}, 16'h00FF);
      end
   endtask

   task automatic t_demux;
      for (int a = 0; a < 8; a++) begin
         for (int d = 0; d < 2; d++) begin
            drive8(3'(a), 1'b1, 1'(d), 1'b0);
            check("R5 demux line", {15'd0, o8[a]}, 16'(d));
            check("R5 demux others", {8'h00, o8 | (8'd1 << a)}, 16'h00FF);
         end
      end
   endtask

   task automatic t_decode16;
      for (int a = 0; a < 16; a++) begin
         drive16(4'(a), 1'b1, 1'b0, 1'b0);
         check("R6 decode16", o16, ~(16'd1 << a));
         check("R8 single low 16", 16'($countones(~o16)), 16'd1);
      end
   endtask

   task automatic t_disable16;
      for (int a = 0; a < 16; a += 5) begin
         drive16(4'(a), 1'b0, 1'b0, 1'b0);
         check("R7 en_hi off", o16, 16'hFFFF);
         drive16(4'(a), 1'b1, 1'b1, 1'b0);
         check("R7 en_lo_a_n off", o16, 16'hFFFF);
         drive16(4'(a), 1'b1, 1'b0, 1'b1);
         check("R7 en_lo_b_n off", o16, 16'hFFFF);
      end
   endtask

   initial begin
      a8 = 3'd0; hi8 = 1'b0; la8 = 1'b1; lb8 = 1'b1;
      a16 = 4'd0; hi16 = 1'b0; la16 = 1'b1; lb16 = 1'b1;
      t_idle();
      t_decode8();
      t_disable8();
      t_demux();
      t_decode16();
      t_disable16();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule